// File: doc/BRIEF.md
# Asynchronous Strobe Bus Write Front End

This block sits behind the pins of a parallel memory bus whose chip-enable, write-enable and output-enable strobes are asynchronous and active low. It samples them with a fast internal clock, which is much faster than any bus cycle. It removes strobe pulses too short to be real, and it turns each valid write window into one clean single-cycle write event. That event carries the address and data latched from the bus, and it goes to a command sequencer.

The block also produces a data-drive enable for the readback mux and the pad drivers. It reports standby while chip-enable is deasserted. It counts how long the bus has been quiet and raises an automatic-standby flag after a set idle time. This flag does not interrupt a read that is already driving data.

The combined write strobe is active while both chip-enable and write-enable are low. It therefore opens when the later of the two falls and closes when the earlier of the two rises. The address is taken at the opening and the data at the closing.

Top module: `strobe_bus_front`

## Requirements
- R1: Each accepted write window produces exactly one `wr_evt` pulse, one clock wide, a few cycles after the filtered combined strobe closes. `wr_addr` and `wr_data` hold the values of that write from the pulse onward.
- R2: `wr_addr` is the address present on the bus when the combined strobe opened, which is when the later of chip-enable and write-enable went low. Address changes later in the window are ignored.
- R3: `wr_data` is the data present on the bus at the moment the combined strobe closed, which is when the first of chip-enable and write-enable went high.
- R4: If output-enable is low at any point inside the filtered write window, no write event is produced.
- R5: While chip-enable is high, `standby` is 1, `dq_oe` is 0, and write-enable pulses of any length produce no write event.
- R6: `dq_oe` is 1 only while chip-enable and output-enable are low and write-enable is high.
- R7: A strobe level must be held for `FILT` (default 5) consecutive samples before it is accepted. A chip-enable or write-enable low pulse shorter than that produces no write event. A pulse of exactly `FILT` samples is accepted.
- R8: After `IDLE_LIM` (default 150) samples with no change on any strobe, address or data pin, `auto_stby` becomes 1. Any such change clears it. It has no effect on `dq_oe`, and it can assert while a write window is open.
- R9: After reset, `wr_evt`, `dq_oe` and `auto_stby` are 0 and `standby` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low reset |
| bus_ce_n | input | 1 | Chip-enable strobe, active low, asynchronous |
| bus_we_n | input | 1 | Write-enable strobe, active low, asynchronous |
| bus_oe_n | input | 1 | Output-enable strobe, active low, asynchronous |
| bus_addr | input | AW | Bus address |
| bus_din | input | DW | Bus write data |
| wr_evt | output | 1 | Single-cycle write event |
| wr_addr | output | AW | Address of the last write event |
| wr_data | output | DW | Data of the last write event |
| dq_oe | output | 1 | Data bus drive enable for reads |
| standby | output | 1 | Chip not selected |
| auto_stby | output | 1 | Bus idle for at least IDLE_LIM samples |

## Verification
The idle timer and an open write window can overlap. A write strobe that is held steady for longer than the idle limit looks like a quiet bus, so automatic standby asserts in the middle of the write. The bench provokes this by holding the strobe with address and data unchanged for 170 cycles, and it checks that `auto_stby` is high while the window is still open. It then releases the strobe and checks three things: the write event still fires once, it carries the address from the opening and the data from the closing, and the release clears `auto_stby`.

// File: rtl/strobe_bus_front.sv
module strobe_bus_front #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int FILT     = 5,
  parameter int IDLE_LIM = 150
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_ce_n,
  input  logic          bus_we_n,
  input  logic          bus_oe_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_din,
  output logic          wr_evt,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          dq_oe,
  output logic          standby,
  output logic          auto_stby
);
  localparam int FW = $clog2(FILT + 1);
  localparam int IW = $clog2(IDLE_LIM + 1);

  // bit 0 chip enable, bit 1 write enable, bit 2 output enable
  logic [2:0]    s1, s2, flt;
  logic [FW-1:0] cnt [3];
  logic [AW-1:0] a1, a2, apend;
  logic [DW-1:0] d1, d2, dpend;
  logic          ws_sq, ws_fq, bad;
  logic [IW-1:0] icnt;

  wire ws_s = ~s2[0] & ~s2[1];
  wire ws_f = ~flt[0] & ~flt[1];
  wire act  = (s2 != s1) || (a2 != a1) || (d2 != d1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
      flt <= '1;
      a1 <= '0;
      a2 <= '0;
      d1 <= '0;
      d2 <= '0;
      for (int i = 0; i < 3; i++) cnt[i] <= '0;
    end else begin
      s1 <= {bus_oe_n, bus_we_n, bus_ce_n};
      s2 <= s1;
      a1 <= bus_addr;
      a2 <= a1;
      d1 <= bus_din;
      d2 <= d1;
      for (int i = 0; i < 3; i++) begin
        if (s2[i] == flt[i]) cnt[i] <= '0;
        else if (cnt[i] == FW'(FILT - 1)) begin
          flt[i] <= s2[i];
          cnt[i] <= '0;
        end else cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_sq   <= 1'b0;
      ws_fq   <= 1'b0;
      apend   <= '0;
      dpend   <= '0;
      bad     <= 1'b0;
      wr_evt  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      ws_sq <= ws_s;
      ws_fq <= ws_f;
      if (ws_s && !ws_sq && !ws_f) apend <= a2;
      if (ws_s) dpend <= d2;
      if (ws_f && !ws_fq) bad <= ~flt[2];
      else if (ws_f) bad <= bad | ~flt[2];
      wr_evt <= 1'b0;
      if (!ws_f && ws_fq && !bad) begin
        wr_evt  <= 1'b1;
        wr_addr <= apend;
        wr_data <= dpend;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) icnt <= '0;
    else if (act) icnt <= '0;
    else if (icnt != IW'(IDLE_LIM)) icnt <= icnt + 1'b1;
  end

  assign auto_stby = (icnt == IW'(IDLE_LIM));
  assign standby   = flt[0];
  assign dq_oe     = ~flt[0] & ~flt[2] & flt[1];

  p_evt_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ws_f && ws_fq) |=> $stable(apend));
  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ws_s && !ws_sq) |=> $stable(dpend));
  p_oe_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> $past(flt[2], 2));
  p_ce_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> $past(!flt[0], 2));
  p_filter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flt[1] != $past(flt[1])) |-> ($past(cnt[1]) == FW'(FILT - 1)));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_stby && !act) |=> auto_stby);
endmodule

// File: tb/sim_strobe_bus_front.sv
module sim_strobe_bus_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [15:0] addr = '0, din = '0;
  logic wr_evt, dq_oe, standby, auto_stby;
  logic [15:0] wr_addr, wr_data;

  int checks = 0, errors = 0, evt_cnt = 0;
  logic [15:0] cap_a = '0, cap_d = '0;
  logic prev_evt = 1'b0, dbl = 1'b0;

  always #5 clk = ~clk;

  strobe_bus_front u0 (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n),
    .bus_oe_n(oe_n), .bus_addr(addr), .bus_din(din), .wr_evt(wr_evt),
    .wr_addr(wr_addr), .wr_data(wr_data), .dq_oe(dq_oe),
    .standby(standby), .auto_stby(auto_stby)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_evt) begin
        evt_cnt++;
        cap_a = wr_addr;
        cap_d = wr_data;
      end
      if (wr_evt && prev_evt) dbl = 1'b1;
      prev_evt = wr_evt;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(wr_evt == 1'b0, "R9 evt", 32'(wr_evt), 0);
    chk(dq_oe == 1'b0, "R9 dq_oe", 32'(dq_oe), 0);
    chk(standby == 1'b1, "R9 standby", 32'(standby), 1);
    chk(auto_stby == 1'b0, "R9 auto_stby", 32'(auto_stby), 0);
  endtask

  task automatic t_we_write(input logic [15:0] a0, input logic [15:0] a1, input logic [15:0] d);
    int e0 = evt_cnt;
    ce_n = 0; cyc(2);
    addr = a0; we_n = 0; cyc(3);
    addr = a1; din = d; cyc(6);
    we_n = 1; cyc(1);
    din = ~d; addr = ~a0; cyc(12);
    ce_n = 1; cyc(12);
    chk(evt_cnt == e0 + 1, "R1 we-write count", 32'(evt_cnt - e0), 1);
    chk(cap_a == a0, "R2 we-write addr", 32'(cap_a), 32'(a0));
    chk(cap_d == d, "R3 we-write data", 32'(cap_d), 32'(d));
  endtask

  task automatic t_ce_write(input logic [15:0] a0, input logic [15:0] d);
    int e0 = evt_cnt;
    addr = ~a0; we_n = 0; cyc(3);
    addr = a0; ce_n = 0; cyc(4);
    addr = a0 ^ 16'h00ff; cyc(4);
    din = d; cyc(2);
    ce_n = 1; cyc(1);
    din = ~d; cyc(2);
    we_n = 1; cyc(12);
    chk(evt_cnt == e0 + 1, "R1 ce-write count", 32'(evt_cnt - e0), 1);
    chk(cap_a == a0, "R2 ce-write addr", 32'(cap_a), 32'(a0));
    chk(cap_d == d, "R3 ce-write data", 32'(cap_d), 32'(d));
  endtask

  task automatic t_glitch();
    int e0 = evt_cnt;
    ce_n = 0; cyc(8);
    we_n = 0; cyc(4);
    we_n = 1; cyc(15);
    ce_n = 1; cyc(15);
    chk(evt_cnt == e0, "R7 we glitch", 32'(evt_cnt - e0), 0);
    we_n = 0; cyc(8);
    ce_n = 0; cyc(4);
    ce_n = 1; cyc(3);
    chk(standby == 1'b1, "R7 ce glitch standby", 32'(standby), 1);
    cyc(12);
    we_n = 1; cyc(15);
    chk(evt_cnt == e0, "R7 ce glitch", 32'(evt_cnt - e0), 0);
    ce_n = 0; addr = 16'h0505; din = 16'h5a5a; cyc(8);
    we_n = 0; cyc(5);
    we_n = 1; cyc(15);
    ce_n = 1; cyc(12);
    chk(evt_cnt == e0 + 1, "R7 exact-width pulse", 32'(evt_cnt - e0), 1);
    chk(cap_d == 16'h5a5a, "R7 exact-width data", 32'(cap_d), 32'h5a5a);
  endtask

  task automatic t_oe_bad();
    int e0 = evt_cnt;
    ce_n = 0; we_n = 0; cyc(10);
    oe_n = 0; cyc(6);
    oe_n = 1; cyc(4);
    we_n = 1; cyc(15);
    ce_n = 1; cyc(12);
    chk(evt_cnt == e0, "R4 oe low in window", 32'(evt_cnt - e0), 0);
  endtask

  task automatic t_ce_high();
    int e0 = evt_cnt;
    oe_n = 0; we_n = 0; cyc(20);
    chk(dq_oe == 1'b0, "R5 no drive while deselected", 32'(dq_oe), 0);
    chk(standby == 1'b1, "R5 standby", 32'(standby), 1);
    we_n = 1; oe_n = 1; cyc(12);
    chk(evt_cnt == e0, "R5 no event while deselected", 32'(evt_cnt - e0), 0);
  endtask

  task automatic t_read();
    ce_n = 0; oe_n = 0; cyc(10);
    chk(dq_oe == 1'b1, "R6 read drive", 32'(dq_oe), 1);
    chk(standby == 1'b0, "R5 selected", 32'(standby), 0);
    we_n = 0; cyc(10);
    chk(dq_oe == 1'b0, "R6 no drive while we low", 32'(dq_oe), 0);
    we_n = 1; cyc(100);
    chk(auto_stby == 1'b0, "R8 before limit", 32'(auto_stby), 0);
    cyc(60);
    chk(auto_stby == 1'b1, "R8 idle standby", 32'(auto_stby), 1);
    chk(dq_oe == 1'b1, "R8 read still driving", 32'(dq_oe), 1);
    addr = addr + 16'd1; cyc(4);
    chk(auto_stby == 1'b0, "R8 cleared by activity", 32'(auto_stby), 0);
    oe_n = 1; ce_n = 1; cyc(12);
  endtask

  task automatic t_long_write();
    int e0 = evt_cnt;
    ce_n = 0; addr = 16'hbeef; din = 16'h1234; we_n = 0; cyc(170);
    chk(auto_stby == 1'b1, "R8 standby inside open window", 32'(auto_stby), 1);
    we_n = 1; cyc(12);
    chk(evt_cnt == e0 + 1, "R1 long write count", 32'(evt_cnt - e0), 1);
    chk(cap_a == 16'hbeef && cap_d == 16'h1234, "R1 long write payload",
        {cap_a, cap_d}, 32'hbeef1234);
    chk(auto_stby == 1'b0, "R8 release clears standby", 32'(auto_stby), 0);
    ce_n = 1; cyc(12);
  endtask

  logic done = 1'b0;

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    t_reset();
    cyc(5);
    t_we_write(16'h1111, 16'h2222, 16'hc3a5);
    t_ce_write(16'h4321, 16'h0f0f);
    t_glitch();
    t_oe_bad();
    t_ce_high();
    t_read();
    t_long_write();
    chk(dbl == 1'b0, "R1 single-cycle pulse", 32'(dbl), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule